// File: doc/BRIEF.md
# Memory access timer with wait stall

This block times a single access to an external memory device. A start pulse in the idle state launches an access of a programmed length, counted in clock cycles numbered 1 to N. While the access runs, a cycle counter steps through the cycles and moves a set of strobe outputs at the cycle positions programmed for each strobe. The strobe outputs are registered, so each strobe changes only on a clock edge. The configuration is captured at the start pulse, so the caller may change it freely once the access has begun.

A slow device can stretch the access through a wait input. The block samples that input once per access, and only when waiting is enabled and the access is at least four cycles long. The sample point is the edge that closes cycle N/2 for an even N, and the edge that closes cycle (N+1)/2 for an odd N. A high sample freezes the counter and the strobes from the following cycle onward. The wait input is then read on every edge, and counting resumes after the first edge that reads it low.

The controller has three states. IDLE goes to RUN on a start pulse (transition "launch"). RUN goes back to IDLE after the final counted cycle ("finish"), or to STALL when the sample point reads wait high ("hold"). STALL stays in STALL while wait reads high ("extend") and returns to RUN when wait reads low ("release").

Top module: `xacc_timer`

## Requirements
- R1: After reset, and whenever no access is in progress, busy_o is low, done_o is low and every strobe output is low.
- R2: A start_i high seen in the idle state begins an access. busy_o is high from the next cycle through the last counted cycle. done_o is high for exactly one cycle, the N-th counted cycle. A duration field of 0 is treated as 1.
- R3: Strobe k is set by the edge that begins counted cycle on_k and cleared by the edge that begins cycle off_k, with clear winning when the two are equal. Field k of the on and off buses is bits [k*DUR_W +: DUR_W]. A position of 0, or one above N, never takes effect. All strobes go low at the edge that ends the access.
- R4: The duration, strobe positions and wait enable are captured at the start pulse. Changes to them, and further start pulses, have no effect while busy_o is high.
- R5: The wait input has no effect when wait_en_i was low at the start pulse, or when N is below 4.
- R6: When sampling applies, wait_i is read only at the edge that closes cycle N/2 for an even N, or cycle (N+1)/2 for an odd N. A high at any earlier edge has no effect.
- R7: A high read at the sample point freezes the counter and the strobes from the next cycle onward. Strobe edges due at the sampling edge itself still happen. The access grows by one cycle for each consecutive edge that reads wait high, starting with the sample edge. done_o stays low while frozen.
- R8: After counting resumes, wait_i is not read again in the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, acted on only when idle |
| dur_i | input | DUR_W | Access length N in cycles (0 means 1) |
| stb_on_i | input | NSTB*DUR_W | Set position of each strobe |
| stb_off_i | input | NSTB*DUR_W | Clear position of each strobe |
| wait_en_i | input | 1 | Enables sampling of the wait input |
| wait_i | input | 1 | Wait request from the device, synchronous to clk |
| stb_o | output | NSTB | Strobe outputs |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | High in the last counted cycle |

## Verification
The bench builds the block with DUR_W = 5 and NSTB = 3. This gives durations up to 31 and three independent strobes. With these values the bench can exercise the zero-duration case, the four-cycle minimum for sampling, both even and odd sample points, and a sample point deep inside a 31-cycle access. Three strobes allow a single access to place one strobe edge on the sampling edge, one on the frozen edge after it, and one out of range.

// File: rtl/xacc_pkg.sv
package xacc_pkg;

    // sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } xacc_state_e;

    // shortest access for which the wait input is looked at
    localparam int WAIT_MIN_LEN = 4;

endpackage

// File: rtl/xacc_ctrl.sv
module xacc_ctrl
    import xacc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        last_i,
    input  logic        samp_pt_i,
    input  logic        wait_i,
    output xacc_state_e state_o,
    output logic        load_o,
    output logic        adv_o,
    output logic        finish_o,
    output logic        busy_o,
    output logic        done_o
);

    xacc_state_e state_q;
    xacc_state_e state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RUN;            // launch
            end
            ST_RUN: begin
                if (last_i)                      state_d = ST_IDLE;  // finish
                else if (samp_pt_i && wait_i)    state_d = ST_STALL; // hold
            end
            ST_STALL: begin
                if (!wait_i) state_d = ST_RUN;            // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        adv_o    = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
            end
            ST_RUN: begin
                busy_o   = 1'b1;
                done_o   = last_i;
                finish_o = last_i;
                adv_o    = !last_i;
            end
            ST_STALL: begin
                busy_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/xacc_cfg.sv
module xacc_cfg #(
    parameter int DUR_W = 5,
    parameter int NSTB  = 2,
    localparam int PW   = NSTB * DUR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic [PW-1:0]    on_i,
    input  logic [PW-1:0]    off_i,
    input  logic             wen_i,
    output logic [DUR_W-1:0] n_q,
    output logic             wen_q,
    output logic [PW-1:0]    on_use,
    output logic [PW-1:0]    off_use
);

    logic [PW-1:0]    on_q;
    logic [PW-1:0]    off_q;
    logic [DUR_W-1:0] dur_eff;

    // a zero length is run as a single cycle
    assign dur_eff = (dur_i == '0) ? DUR_W'(1) : dur_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q   <= DUR_W'(1);
            wen_q <= 1'b0;
            on_q  <= '0;
            off_q <= '0;
        end else if (load_i) begin
            n_q   <= dur_eff;
            wen_q <= wen_i;
            on_q  <= on_i;
            off_q <= off_i;
        end
    end

    // the strobe edges for cycle 1 are applied on the load edge itself,
    // so the live positions are passed through while loading
    assign on_use  = load_i ? on_i  : on_q;
    assign off_use = load_i ? off_i : off_q;

endmodule

// File: rtl/xacc_count.sv
module xacc_count
    import xacc_pkg::*;
#(
    parameter int DUR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [DUR_W-1:0] n_q,
    input  logic             wen_q,
    output logic [DUR_W-1:0] cnt_q,
    output logic [DUR_W-1:0] nxt_o,
    output logic             last_o,
    output logic             samp_pt_o
);

    localparam int XW = DUR_W + 1;

    logic [XW-1:0] half;
    logic          long_enough;

    // sample cycle: ceil(N/2)
    assign half        = ({1'b0, n_q} + XW'(1)) >> 1;
    assign long_enough = (n_q >= DUR_W'(WAIT_MIN_LEN));
    assign samp_pt_o   = wen_q && long_enough && (cnt_q == half[DUR_W-1:0]);
    assign last_o      = (cnt_q == n_q);

    // cycle number that the coming edge enters
    assign nxt_o = load_i ? DUR_W'(1) : (cnt_q + DUR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load_i || adv_i)  cnt_q <= nxt_o;
    end

endmodule

// File: rtl/xacc_strobe.sv
module xacc_strobe #(
    parameter int DUR_W = 5,
    parameter int NSTB  = 2,
    localparam int PW   = NSTB * DUR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             clr_i,
    input  logic [DUR_W-1:0] pos_i,
    input  logic [PW-1:0]    on_i,
    input  logic [PW-1:0]    off_i,
    output logic [NSTB-1:0]  stb_o
);

    for (genvar k = 0; k < NSTB; k++) begin : g_stb
        logic [DUR_W-1:0] on_k;
        logic [DUR_W-1:0] off_k;
        assign on_k  = on_i[k*DUR_W +: DUR_W];
        assign off_k = off_i[k*DUR_W +: DUR_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stb_o[k] <= 1'b0;
            end else if (clr_i) begin
                stb_o[k] <= 1'b0;
            end else if (fire_i) begin
                if (pos_i == off_k)     stb_o[k] <= 1'b0;
                else if (pos_i == on_k) stb_o[k] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/xacc_timer.sv
module xacc_timer
    import xacc_pkg::*;
#(
    parameter int DUR_W = 5,
    parameter int NSTB  = 2,
    localparam int PW   = NSTB * DUR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic [PW-1:0]    stb_on_i,
    input  logic [PW-1:0]    stb_off_i,
    input  logic             wait_en_i,
    input  logic             wait_i,
    output logic [NSTB-1:0]  stb_o,
    output logic             busy_o,
    output logic             done_o
);

    xacc_state_e      state_q;
    logic             load;
    logic             adv;
    logic             finish;
    logic             last;
    logic             samp_pt;
    logic [DUR_W-1:0] n_q;
    logic             wen_q;
    logic [PW-1:0]    on_use;
    logic [PW-1:0]    off_use;
    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] nxt;

    xacc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .last_i    (last),
        .samp_pt_i (samp_pt),
        .wait_i    (wait_i),
        .state_o   (state_q),
        .load_o    (load),
        .adv_o     (adv),
        .finish_o  (finish),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    xacc_cfg #(.DUR_W(DUR_W), .NSTB(NSTB)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .dur_i   (dur_i),
        .on_i    (stb_on_i),
        .off_i   (stb_off_i),
        .wen_i   (wait_en_i),
        .n_q     (n_q),
        .wen_q   (wen_q),
        .on_use  (on_use),
        .off_use (off_use)
    );

    xacc_count #(.DUR_W(DUR_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .adv_i     (adv),
        .n_q       (n_q),
        .wen_q     (wen_q),
        .cnt_q     (cnt_q),
        .nxt_o     (nxt),
        .last_o    (last),
        .samp_pt_o (samp_pt)
    );

    xacc_strobe #(.DUR_W(DUR_W), .NSTB(NSTB)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (load | adv),
        .clr_i  (finish),
        .pos_i  (nxt),
        .on_i   (on_use),
        .off_i  (off_use),
        .stb_o  (stb_o)
    );

endmodule

// File: rtl/xacc_timer_chk.sv
module xacc_timer_chk
    import xacc_pkg::*;
#(
    parameter int DUR_W = 5,
    parameter int NSTB  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [NSTB-1:0]  stb_o,
    input logic             busy_o,
    input logic             done_o,
    input xacc_state_e      state_q,
    input logic [DUR_W-1:0] cnt_q,
    input logic [DUR_W-1:0] n_q,
    input logic             wen_q
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (stb_o == '0) && !done_o);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q >= DUR_W'(1)) && (cnt_q <= n_q));

    p_stall_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> wen_q && (n_q >= DUR_W'(WAIT_MIN_LEN)));

    p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |=> $stable(cnt_q) && $stable(stb_o) && busy_o);

    p_stall_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> !done_o);

endmodule

bind xacc_timer xacc_timer_chk #(.DUR_W(DUR_W), .NSTB(NSTB)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stb_o   (stb_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_q (state_q),
    .cnt_q   (cnt_q),
    .n_q     (n_q),
    .wen_q   (wen_q)
);

// File: tb/test_xacc_timer.sv
module test_xacc_timer;

    localparam int DW = 5;
    localparam int NS = 3;

    typedef struct {
        logic [NS-1:0] stb;
        logic          busy;
        logic          done;
        string         tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DW-1:0]    dur_i = '0;
    logic [NS*DW-1:0] stb_on_i = '0;
    logic [NS*DW-1:0] stb_off_i = '0;
    logic             wait_en_i = 1'b0;
    logic             wait_i = 1'b0;
    logic [NS-1:0]    stb_o;
    logic             busy_o;
    logic             done_o;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    xacc_timer #(.DUR_W(DW), .NSTB(NS)) i_xacc_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .dur_i     (dur_i),
        .stb_on_i  (stb_on_i),
        .stb_off_i (stb_off_i),
        .wait_en_i (wait_en_i),
        .wait_i    (wait_i),
        .stb_o     (stb_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    // monitor: compare one expected item per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (stb_o !== e.stb || busy_o !== e.busy || done_o !== e.done) begin
                errors++;
                $display("FAIL %s: stb=%b busy=%b done=%b, expected stb=%b busy=%b done=%b",
                         e.tag, stb_o, busy_o, done_o, e.stb, e.busy, e.done);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got %0d cycles, expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push(input logic [NS-1:0] s, input logic b, input logic d, input string tag);
        exp_t e;
        e.stb = s; e.busy = b; e.done = d; e.tag = tag;
        q.push_back(e);
    endtask

    // driver: runs one access and pushes the expected outputs of each cycle
    task automatic run_access(input int dur, input int on0, input int on1, input int on2,
                              input int of0, input int of1, input int of2,
                              input bit wen, input int hi, input bit noise, input bit scr,
                              input string tag);
        int ons[NS];
        int offs[NS];
        int eff, spt, c, hcnt;
        bit smp, frz, fin, w;
        logic [NS-1:0] sm;
        ons[0] = on0; ons[1] = on1; ons[2] = on2;
        offs[0] = of0; offs[1] = of1; offs[2] = of2;
        eff = (dur == 0) ? 1 : dur;
        spt = (eff + 1) / 2;
        smp = wen && (eff >= 4);
        start_i   = 1'b1;
        dur_i     = DW'(dur);
        stb_on_i  = {DW'(on2), DW'(on1), DW'(on0)};
        stb_off_i = {DW'(of2), DW'(of1), DW'(of0)};
        wait_en_i = wen;
        wait_i    = 1'b0;
        push('0, 1'b0, 1'b0, {tag, " R1 idle"});
        @(posedge clk); #1;
        c = 1; frz = 1'b0; fin = 1'b0; hcnt = 0; sm = '0;
        for (int k = 0; k < NS; k++) begin
            if (c == offs[k])     sm[k] = 1'b0;
            else if (c == ons[k]) sm[k] = 1'b1;
        end
        while (!fin) begin
            push(sm, 1'b1, (!frz && c == eff), tag);
            start_i = scr;
            if (scr) begin
                dur_i     = DW'(2);
                stb_on_i  = ~stb_on_i;
                stb_off_i = ~stb_off_i;
                wait_en_i = ~wen;
            end
            w = noise;
            if (!frz && c == spt) w = (hi > 0);
            if (frz)              w = (hcnt < hi);
            wait_i = w;
            @(posedge clk); #1;
            if (frz) begin
                if (hcnt < hi) hcnt++;
                else           frz = 1'b0;
            end else if (c == eff) begin
                fin = 1'b1;
            end else begin
                if (smp && c == spt && hi > 0) begin
                    frz = 1'b1;
                    hcnt = 1;
                end
                c++;
                for (int k = 0; k < NS; k++) begin
                    if (c == offs[k])     sm[k] = 1'b0;
                    else if (c == ons[k]) sm[k] = 1'b1;
                end
            end
        end
        start_i = 1'b0;
        wait_i  = 1'b0;
    endtask

    initial begin
        #23 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy_o !== 1'b0 || done_o !== 1'b0 || stb_o !== '0) begin
            errors++;
            $display("FAIL R1 reset: stb=%b busy=%b done=%b, expected 000 0 0", stb_o, busy_o, done_o);
        end
        @(posedge clk); #1;

        run_access(3, 1, 2, 5, 3, 0, 6, 1'b1, 2, 1'b1, 1'b0, "R2 R3 R5 short access ignores wait");
        run_access(6, 2, 1, 4, 5, 6, 0, 1'b1, 0, 1'b1, 1'b0, "R6 even sample point low");
        run_access(6, 4, 5, 1, 6, 0, 5, 1'b1, 1, 1'b0, 1'b0, "R7 even stall one cycle");
        run_access(7, 4, 5, 2, 7, 6, 3, 1'b1, 3, 1'b1, 1'b0, "R6 R7 R8 odd stall three cycles");
        run_access(8, 1, 4, 8, 8, 5, 0, 1'b0, 4, 1'b1, 1'b0, "R5 wait disabled");
        run_access(0, 1, 1, 0, 0, 2, 1, 1'b1, 0, 1'b0, 1'b0, "R2 zero duration");
        run_access(5, 2, 3, 1, 2, 4, 5, 1'b0, 0, 1'b0, 1'b0, "R3 equal positions");
        run_access(9, 3, 1, 6, 8, 9, 7, 1'b1, 2, 1'b0, 1'b1, "R4 config and start changes ignored");
        run_access(31, 16, 17, 1, 31, 18, 30, 1'b1, 2, 1'b1, 1'b0, "R2 R7 longest access");
        run_access(4, 2, 3, 1, 4, 4, 3, 1'b1, 1, 1'b0, 1'b0, "R5 R7 minimum sampled length");

        for (int i = 0; i < 3; i++) begin
            push('0, 1'b0, 1'b0, "R1 idle after access");
            @(posedge clk); #1;
        end
        while (q.size() > 0) @(posedge clk);
        @(posedge clk); #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule